// File: doc/BRIEF.md
# External Interrupt Pin Controller

The block watches up to eight external interrupt pins. Each pin goes through its own synchronizer and a detector, and the trigger for the detector is chosen per pin from five choices: falling edge, rising edge, low level, high level or both edges. When a pin's trigger fires, the block records a pending request for that pin. A pin's interrupt output is driven when its request is pending, the pin is not masked and its priority field is nonzero. A single combined output, the OR of all per-pin outputs, serves a parent that shares one line among all the pins.

Software controls the block through a small word-addressed register port, where each access takes one cycle. The port holds the trigger configuration, the priority fields, the pending flags, a write-one-to-mask register and a write-one-to-unmask register. A mode register carries an individual-interrupt-mode flag that is passed straight to an output pin. The current mask state can be read back at its own address. Per-pin fields are packed from the top of each word, so pin 0 always sits in the most significant field or bit. The register port is a plain control path and has no back-pressure: a write takes effect at the clock edge where `reg_we` is high, and read data reflects the addressed register in the same cycle.

Top module: `eipc_top`

## Requirements
- R1: After reset all pins are masked (address 6 reads 0xFF), all priority fields and trigger fields are 0, no request is pending, and irq_out, irq_any and indiv_mode are low.
- R2: The trigger register (address 0) gives pin n a SENSE_W-bit field at bits [32-(n+1)*SENSE_W +: SENSE_W]. The register reads back as written for the pin fields, and other bits read 0.
- R3: The priority register (address 1) gives pin n a 4-bit field at bits [32-(n+1)*4 +: 4]. A zero field keeps that pin's output low whatever its pending and mask state, and any nonzero value (0xF is the normal one) lets the output through.
- R4: Trigger code 0 latches a request on a falling pin and code 1 on a rising pin. The request becomes visible three clock edges after the pin changes: two synchronizer stages, then the pending flop.
- R5: Trigger code 4 latches a request on either transition of the pin.
- R6: Trigger code 2 (low) and code 3 (high) set the request on every cycle that the synchronized pin is at the active level, so an attempt to clear it has no effect while the level persists.
- R7: The source register (address 2) shows pin n's request at bit SRC_W-1-n. A write clears each request whose bit is written 0 and keeps each whose bit is written 1. A detection in the same cycle as the clear wins over the clear.
- R8: Writing address 3 masks pin n where bit SRC_W-1-n is 1. Bits written 0 do nothing.
- R9: Writing address 4 unmasks pin n where bit SRC_W-1-n is 1. Bits written 0 do nothing.
- R10: irq_out[n] is high exactly when pin n is pending, unmasked and has a nonzero priority field. irq_any is the OR of irq_out.
- R11: The mode register (address 5) stores only bit 23, which reads back in place and drives indiv_mode. All other bits read 0.
- R12: Trigger codes 5 to 15 never raise a request.
- R13: Addresses 3 and 4 read 0. Address 6 reads the mask state with pin n at bit SRC_W-1-n, and a 1 means masked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | External interrupt pins, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| irq_out | output | NUM_PINS | Per-pin interrupt outputs |
| irq_any | output | 1 | OR of all per-pin outputs |
| indiv_mode | output | 1 | Individual-interrupt-mode flag from the mode register |

## Verification
On every cycle the assertions check four things: a detection always leaves its request pending on the next edge, a zero-written source bit clears a request that has no detection in the same cycle, mask writes reach the mask state one edge later, and an output is never high for a pin that is not pending, is masked or has zero priority. Some behaviours only the bench scenarios can show, because they depend on pin history and field layout. These are the three-edge latency from pin to request, edge versus level retriggering after a clear, both-edge detection, invalid trigger codes staying silent, and the packed MSB-first placement of every field. The behavioural reference model confirms all of these cycle by cycle under random pin activity and random register traffic.

// File: rtl/eipc_pkg.sv
package eipc_pkg;

  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;
  localparam int PRIO_W = 4;
  localparam int MODE_BIT = 23;

  typedef enum logic [ADDR_W-1:0] {
    SEL_TRIG  = 3'd0,
    SEL_PRIO  = 3'd1,
    SEL_SRC   = 3'd2,
    SEL_MSET  = 3'd3,
    SEL_MCLR  = 3'd4,
    SEL_MODE  = 3'd5,
    SEL_MSTAT = 3'd6
  } reg_sel_e;

  typedef enum logic [3:0] {
    TRIG_FALL = 4'd0,
    TRIG_RISE = 4'd1,
    TRIG_LOW  = 4'd2,
    TRIG_HIGH = 4'd3,
    TRIG_BOTH = 4'd4
  } trig_e;

  // cur: synchronized sample now, prev: sample one cycle earlier
  function automatic logic trig_hit(input logic [3:0] code, input logic cur, input logic prev);
    case (code)
      TRIG_FALL: return prev & ~cur;
      TRIG_RISE: return ~prev & cur;
      TRIG_LOW:  return ~cur;
      TRIG_HIGH: return cur;
      TRIG_BOTH: return prev ^ cur;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/eipc_sync.sv
module eipc_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage_a;
  logic [W-1:0] stage_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_a <= '0;
      stage_b <= '0;
    end else begin
      stage_a <= din;
      stage_b <= stage_a;
    end
  end

  assign dout = stage_b;

endmodule

// File: rtl/eipc_detect.sv
module eipc_detect
  import eipc_pkg::*;
#(
  parameter int NP = 8,
  parameter int SW = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NP-1:0]         pin_sync,
  input  logic [NP-1:0][SW-1:0] trig_cfg,
  output logic [NP-1:0]         evt
);

  logic [NP-1:0] pin_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev <= '0;
    else        pin_prev <= pin_sync;
  end

  for (genvar n = 0; n < NP; n++) begin : g_pin
    logic [3:0] code;
    assign code   = 4'(trig_cfg[n]);
    assign evt[n] = trig_hit(code, pin_sync[n], pin_prev[n]);
  end

endmodule

// File: rtl/eipc_regs.sv
module eipc_regs
  import eipc_pkg::*;
#(
  parameter int NP    = 8,
  parameter int SW    = 4,
  parameter int SRC_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [REG_W-1:0]          wdata,
  input  logic [NP-1:0]             evt,
  output logic [REG_W-1:0]          rdata,
  output logic [NP-1:0]             pend,
  output logic [NP-1:0]             mask,
  output logic [NP-1:0][SW-1:0]     trig_cfg,
  output logic [NP-1:0][PRIO_W-1:0] prio,
  output logic                      mode
);

  reg_sel_e sel;
  assign sel = reg_sel_e'(addr);

  logic wr_trig, wr_prio, wr_src, wr_mset, wr_mclr, wr_mode;
  assign wr_trig = we && (sel == SEL_TRIG);
  assign wr_prio = we && (sel == SEL_PRIO);
  assign wr_src  = we && (sel == SEL_SRC);
  assign wr_mset = we && (sel == SEL_MSET);
  assign wr_mclr = we && (sel == SEL_MCLR);
  assign wr_mode = we && (sel == SEL_MODE);

  for (genvar n = 0; n < NP; n++) begin : g_pin
    localparam int TRIG_LSB = REG_W - (n + 1) * SW;
    localparam int PRIO_LSB = REG_W - (n + 1) * PRIO_W;
    localparam int BIT_POS  = SRC_W - 1 - n;

    logic keep;
    assign keep = !(wr_src && !wdata[BIT_POS]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[n]     <= 1'b0;
        mask[n]     <= 1'b1;
        trig_cfg[n] <= '0;
        prio[n]     <= '0;
      end else begin
        pend[n] <= evt[n] | (pend[n] & keep);
        if (wr_mset && wdata[BIT_POS])      mask[n] <= 1'b1;
        else if (wr_mclr && wdata[BIT_POS]) mask[n] <= 1'b0;
        if (wr_trig) trig_cfg[n] <= wdata[TRIG_LSB +: SW];
        if (wr_prio) prio[n]     <= wdata[PRIO_LSB +: PRIO_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode <= 1'b0;
    else if (wr_mode) mode <= wdata[MODE_BIT];
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_TRIG: for (int n = 0; n < NP; n++) rdata[REG_W - (n + 1) * SW +: SW] = trig_cfg[n];
      SEL_PRIO: for (int n = 0; n < NP; n++) rdata[REG_W - (n + 1) * PRIO_W +: PRIO_W] = prio[n];
      SEL_SRC:  for (int n = 0; n < NP; n++) rdata[SRC_W - 1 - n] = pend[n];
      SEL_MSTAT: for (int n = 0; n < NP; n++) rdata[SRC_W - 1 - n] = mask[n];
      SEL_MODE: rdata[MODE_BIT] = mode;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/eipc_top.sv
module eipc_top
  import eipc_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SENSE_W  = 4,
  parameter int SRC_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                reg_we,
  input  logic [2:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic [NUM_PINS-1:0] irq_out,
  output logic                irq_any,
  output logic                indiv_mode
);

  logic [NUM_PINS-1:0]              pin_sync;
  logic [NUM_PINS-1:0]              evt;
  logic [NUM_PINS-1:0]              pend_q;
  logic [NUM_PINS-1:0]              mask_q;
  logic [NUM_PINS-1:0][SENSE_W-1:0] trig_q;
  logic [NUM_PINS-1:0][PRIO_W-1:0]  prio_q;

  eipc_sync #(.W(NUM_PINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_in),
    .dout (pin_sync)
  );

  eipc_detect #(.NP(NUM_PINS), .SW(SENSE_W)) u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_sync(pin_sync),
    .trig_cfg(trig_q),
    .evt     (evt)
  );

  eipc_regs #(.NP(NUM_PINS), .SW(SENSE_W), .SRC_W(SRC_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .evt     (evt),
    .rdata   (reg_rdata),
    .pend    (pend_q),
    .mask    (mask_q),
    .trig_cfg(trig_q),
    .prio    (prio_q),
    .mode    (indiv_mode)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_out
    assign irq_out[n] = pend_q[n] & ~mask_q[n] & (|prio_q[n]);
  end

  assign irq_any = |irq_out;

endmodule

// File: rtl/eipc_chk.sv
module eipc_chk #(
  parameter int NP    = 8,
  parameter int SRC_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic [2:0]           reg_addr,
  input logic [31:0]          reg_wdata,
  input logic [NP-1:0]        evt,
  input logic [NP-1:0]        pend,
  input logic [NP-1:0]        mask,
  input logic [NP-1:0][3:0]   prio,
  input logic [NP-1:0]        irq_out
);

  for (genvar n = 0; n < NP; n++) begin : g_pin
    localparam int BP = SRC_W - 1 - n;

    // R4
    evt_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[n] |=> pend[n]);

    // R7
    src_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 3'd2 && !reg_wdata[BP] && !evt[n]) |=> !pend[n]);

    // R8
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 3'd3 && reg_wdata[BP]) |=> mask[n]);

    // R9
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 3'd4 && reg_wdata[BP]) |=> !mask[n]);

    // R10
    out_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out[n] |-> (pend[n] && !mask[n]));

    // R3
    prio_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prio[n] == 4'd0) |-> !irq_out[n]);
  end

endmodule

bind eipc_top eipc_chk #(.NP(NUM_PINS), .SRC_W(SRC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .evt      (evt),
  .pend     (pend_q),
  .mask     (mask_q),
  .prio     (prio_q),
  .irq_out  (irq_out)
);

// File: tb/test_eipc_top.sv
`timescale 1ns/1ps
module test_eipc_top;

  localparam int NP = 8;
  localparam int SW = 4;
  localparam int SRCW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_in = '0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] irq_out;
  logic          irq_any;
  logic          indiv_mode;

  int n_vec = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  eipc_top #(.NUM_PINS(NP), .SENSE_W(SW), .SRC_W(SRCW)) i_eipc_top (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out), .irq_any(irq_any), .indiv_mode(indiv_mode)
  );

  // behavioural reference model
  int m_s1[NP], m_s2[NP], m_prev[NP], m_trig[NP], m_prio[NP];
  bit m_pend[NP], m_mask[NP];
  bit m_mode;

  function automatic bit fires(int code, int cur, int prev);
    if (code == 0) return (prev == 1 && cur == 0);
    if (code == 1) return (prev == 0 && cur == 1);
    if (code == 2) return (cur == 0);
    if (code == 3) return (cur == 1);
    if (code == 4) return (prev != cur);
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NP; n++) begin
        m_s1[n] = 0; m_s2[n] = 0; m_prev[n] = 0; m_trig[n] = 0; m_prio[n] = 0;
        m_pend[n] = 0; m_mask[n] = 1;
      end
      m_mode = 0;
    end else begin
      for (int n = 0; n < NP; n++) begin
        bit hit, keep;
        int bp;
        bp = SRCW - 1 - n;
        hit = fires(m_trig[n], m_s2[n], m_prev[n]);
        keep = !(reg_we && reg_addr == 2 && !reg_wdata[bp]);
        m_pend[n] = hit || (m_pend[n] && keep);
        if (reg_we && reg_addr == 3 && reg_wdata[bp]) m_mask[n] = 1;
        if (reg_we && reg_addr == 4 && reg_wdata[bp]) m_mask[n] = 0;
        if (reg_we && reg_addr == 0) m_trig[n] = int'((reg_wdata >> (32 - (n + 1) * SW)) & ((1 << SW) - 1));
        if (reg_we && reg_addr == 1) m_prio[n] = int'((reg_wdata >> (32 - (n + 1) * 4)) & 15);
        m_prev[n] = m_s2[n]; m_s2[n] = m_s1[n]; m_s1[n] = int'(pin_in[n]);
      end
      if (reg_we && reg_addr == 5) m_mode = reg_wdata[23];
    end
  end

  function automatic logic [31:0] m_read(int a);
    logic [31:0] r = '0;
    for (int n = 0; n < NP; n++) begin
      if (a == 0) r = r | (32'(m_trig[n]) << (32 - (n + 1) * SW));
      if (a == 1) r = r | (32'(m_prio[n]) << (32 - (n + 1) * 4));
      if (a == 2 && m_pend[n]) r[SRCW - 1 - n] = 1'b1;
      if (a == 6 && m_mask[n]) r[SRCW - 1 - n] = 1'b1;
    end
    if (a == 5) r[23] = m_mode;
    return r;
  endfunction

  function automatic logic [NP-1:0] m_irq();
    logic [NP-1:0] v = '0;
    for (int n = 0; n < NP; n++) v[n] = m_pend[n] && !m_mask[n] && (m_prio[n] != 0);
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, 32'(irq_out), 32'(m_irq()));
      chk(cur_req, 32'(irq_any), 32'(|m_irq()));
      chk(cur_req, 32'(indiv_mode), 32'(m_mode));
      chk(cur_req, reg_rdata, m_read(int'(reg_addr)));
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(string req, int a, logic [31:0] exp);
    reg_addr = 3'(a);
    @(negedge clk);
    chk(req, reg_rdata, exp);
  endtask

  task automatic idle(int c);
    repeat (c) @(posedge clk);
    #1;
  endtask

  task automatic pin(int n, bit v);
    @(posedge clk); #1;
    pin_in[n] = v;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    cur_req = "R1";
    rd("R1", 6, 32'h0000_00FF);
    rd("R1", 0, 32'h0);
    rd("R1", 1, 32'h0);
    rd("R1", 2, 32'h0);
    chk("R1", {30'd0, irq_any, indiv_mode}, 32'h0);
    // R2 field layout: pin0 rise, pin1 fall, pin2 low, pin3 high, pin4 both, pin5 code 7
    cur_req = "R2";
    wr(0, 32'h1023_4700);
    rd("R2", 0, 32'h1023_4700);
    // R3 zero priority blocks output
    cur_req = "R3";
    wr(4, 32'h0000_00FF);
    idle(4);
    chk("R3", 32'(irq_out), 32'h0);
    wr(1, 32'h00F0_0000);
    @(negedge clk);
    chk("R3", 32'(irq_out), 32'h04);
    wr(1, 32'hFFFF_FFFF);
    // R4 rising and falling edges
    cur_req = "R4";
    pin(0, 1); idle(4);
    rd("R4", 2, 32'h0000_00A0);
    pin(1, 1); idle(4);
    pin(1, 0); idle(4);
    rd("R4", 2, 32'h0000_00E0);
    // R7 selective clear
    cur_req = "R7";
    wr(2, 32'hFFFF_FFBF);
    rd("R7", 2, 32'h0000_00A0);
    wr(2, 32'h0);
    rd("R7", 2, 32'h0000_0020);
    // R6 level retrigger
    cur_req = "R6";
    pin(2, 1); idle(4);
    wr(2, 32'h0);
    rd("R6", 2, 32'h0);
    pin(2, 0); idle(4);
    rd("R6", 2, 32'h0000_0020);
    // R5 both edges
    cur_req = "R5";
    pin(4, 1); idle(4);
    rd("R5", 2, 32'h0000_0028);
    wr(2, 32'hFFFF_FFF7);
    rd("R5", 2, 32'h0000_0020);
    pin(4, 0); idle(4);
    rd("R5", 2, 32'h0000_0028);
    // R12 invalid code silent
    cur_req = "R12";
    pin(5, 1); idle(4);
    pin(5, 0); idle(4);
    rd("R12", 2, 32'h0000_0028);
    // R8 mask set
    cur_req = "R8";
    wr(3, 32'h0000_0008);
    rd("R8", 6, 32'h0000_0008);
    chk("R8", 32'(irq_out), 32'h04);
    wr(3, 32'h0);
    rd("R8", 6, 32'h0000_0008);
    // R9 mask clear
    cur_req = "R9";
    wr(4, 32'h0000_0008);
    rd("R9", 6, 32'h0);
    wr(4, 32'h0);
    rd("R9", 6, 32'h0);
    // R10 output combination
    cur_req = "R10";
    chk("R10", 32'(irq_out), 32'h14);
    chk("R10", 32'(irq_any), 32'h1);
    // R11 mode register
    cur_req = "R11";
    wr(5, 32'hFFFF_FFFF);
    rd("R11", 5, 32'h0080_0000);
    chk("R11", 32'(indiv_mode), 32'h1);
    wr(5, 32'h0);
    rd("R11", 5, 32'h0);
    // R13 write-only addresses
    cur_req = "R13";
    rd("R13", 3, 32'h0);
    rd("R13", 4, 32'h0);
    // random traffic, compared each cycle (R10)
    cur_req = "R10";
    for (int c = 0; c < 600; c++) begin
      @(posedge clk); #1;
      if ($urandom_range(0, 3) == 0) pin_in[$urandom_range(0, NP - 1)] ^= 1'b1;
      reg_addr = 3'($urandom_range(0, 6));
      reg_we = ($urandom_range(0, 4) == 0);
      reg_wdata = $urandom;
      if (reg_addr == 0) reg_wdata = reg_wdata & 32'h7777_7777;
    end
    reg_we = 1'b0;
    idle(2);
    finish_run();
  end

endmodule